// File: doc/BRIEF.md
# Operate-Instruction Execute Unit

This block is the single-cycle execute stage for the three register-writing arithmetic and logic operations of a 16-bit load/store instruction set: add, bitwise AND and bitwise NOT. It holds its own eight-entry register file. Each cycle it may receive one instruction word, qualified by a valid strobe. On the following clock edge it writes the result to the destination register and updates a three-flag condition code.

The same edge also registers the result on a write-back port: a strobe, the destination index and the value. The surrounding pipeline, or a test environment, can therefore observe each result directly. Any register's contents can be read back by issuing an add of immediate zero to it. Words whose opcode is not one of the three, or that arrive without the valid strobe, change nothing.

Top module: `opx_exec`

## Requirements
- R1: After reset all eight registers hold zero, the flags read N=0 Z=1 P=0, and wr_valid is low.
- R2: Opcode bits [15:12] = 0001 adds. With bit 5 = 0 the second operand is the register indexed by bits [2:0]. The sum wraps modulo 2^16 with no overflow indication (x7000 + x7000 = xE000).
- R3: With bit 5 = 1, add and AND use bits [4:0] as a two's-complement immediate, sign-extended to 16 bits (10001 acts as -15, 11111 as all ones).
- R4: Opcode 0101 performs a bitwise AND of the first source (bits [8:6]) with the second operand chosen as in R2/R3.
- R5: Opcode 1001 writes the bitwise complement of the first source register (bits [8:6]) to the destination (bits [11:9]).
- R6: After every accepted instruction exactly one flag is set: N if the result's bit 15 is 1, Z if the result is zero, P otherwise. Flags and results are visible after the same clock edge that writes the register.
- R7: When in_valid is low, or the opcode is none of 0001, 0101 and 1001, no register changes, the flags hold, and wr_valid stays low.
- R8: A source register that is also the destination supplies its value from before the instruction. The new value is seen only by later instructions.
- R9: One cycle after an accepted instruction, wr_valid is high, and wr_dst and wr_data carry the destination index and the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_instr this cycle |
| in_instr | input | 16 | Instruction word |
| wr_valid | output | 1 | A register was written at the last edge |
| wr_dst | output | 3 | Index of the register written |
| wr_data | output | 16 | Value written |
| flag_n | output | 1 | Condition: last result negative |
| flag_z | output | 1 | Condition: last result zero |
| flag_p | output | 1 | Condition: last result positive |

## Verification
A directed chain first clears a register and loads a small immediate. It then doubles that register into itself until the value wraps past the sign bit. This separates correct modulo addition and pre-write source reads from a design that reads the freshly written value. Negative immediates and the all-ones mask tell sign extension apart from zero extension, and NOT exposes which field is taken as the source. Random instructions in both operand modes, mixed with dropped strobes and foreign opcodes, are compared every cycle against a behavioural model. Register read-back through add-immediate-zero then shows that ignored words altered nothing.

// File: rtl/opx_pkg.sv
package opx_pkg;
    localparam int INSTR_W = 16;
    localparam int IMM_W   = 5;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_ADD  = 2'd1,
        K_AND  = 2'd2,
        K_NOT  = 2'd3
    } kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;
endpackage

// File: rtl/opx_decode.sv
module opx_decode
    import opx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AW     = 3
) (
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output kind_e              kind,
    output logic [AW-1:0]      dst,
    output logic [AW-1:0]      sr1,
    output logic [AW-1:0]      sr2,
    output logic               use_imm,
    output logic [DATA_W-1:0]  imm
);
    localparam int EXT_W = DATA_W - IMM_W;

    always_comb begin
        kind = K_NONE;
        if (in_valid) begin
            unique case (in_instr[15:12])
                4'b0001: kind = K_ADD;
                4'b0101: kind = K_AND;
                4'b1001: kind = K_NOT;
                default: kind = K_NONE;
            endcase
        end
        dst     = in_instr[11:9];
        sr1     = in_instr[8:6];
        sr2     = in_instr[2:0];
        use_imm = in_instr[5];
        imm     = {{EXT_W{in_instr[IMM_W-1]}}, in_instr[IMM_W-1:0]};
    end
endmodule

// File: rtl/opx_alu.sv
module opx_alu
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  kind_e             kind,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (kind)
            K_ADD:   res = opa + opb;
            K_AND:   res = opa & opb;
            K_NOT:   res = ~opa;
            default: res = opa;
        endcase
    end
endmodule

// File: rtl/opx_regfile.sv
module opx_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    // reads see the pre-edge contents (R8)
    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_comb begin
            mem_d[i] = mem_q[i];
            if (we && waddr == AW'(i)) mem_d[i] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end

        // R7: an entry that is not addressed by a write keeps its value
        a_r7_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && waddr == AW'(i)) |=> $stable(mem_q[i]));
    end
endmodule

// File: rtl/opx_exec.sv
module opx_exec
    import opx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               wr_valid,
    output logic [2:0]         wr_dst,
    output logic [DATA_W-1:0]  wr_data,
    output logic               flag_n,
    output logic               flag_z,
    output logic               flag_p
);
    localparam int AW = $clog2(NREG);

    typedef struct packed {
        cc_t               cc;
        logic              wv;
        logic [AW-1:0]     wd;
        logic [DATA_W-1:0] wdat;
    } st_t;

    st_t st_d, st_q;

    kind_e             kind;
    logic [AW-1:0]     dst, sr1, sr2;
    logic              use_imm;
    logic [DATA_W-1:0] imm, rd_a, rd_b, opb, res;
    logic              accept;

    opx_decode #(.DATA_W(DATA_W), .AW(AW)) u_dec (
        .in_valid (in_valid),
        .in_instr (in_instr),
        .kind     (kind),
        .dst      (dst),
        .sr1      (sr1),
        .sr2      (sr2),
        .use_imm  (use_imm),
        .imm      (imm)
    );

    assign accept = (kind != K_NONE);
    assign opb    = use_imm ? imm : rd_b;

    opx_regfile #(.DATA_W(DATA_W), .DEPTH(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (accept),
        .waddr   (dst),
        .wdata   (res),
        .raddr_a (sr1),
        .raddr_b (sr2),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    opx_alu #(.DATA_W(DATA_W)) u_alu (
        .kind (kind),
        .opa  (rd_a),
        .opb  (opb),
        .res  (res)
    );

    always_comb begin
        st_d    = st_q;
        st_d.wv = 1'b0;
        if (accept) begin
            st_d.wv   = 1'b1;
            st_d.wd   = dst;
            st_d.wdat = res;
            st_d.cc.n = res[DATA_W-1];
            st_d.cc.z = (res == '0);
            st_d.cc.p = !res[DATA_W-1] && (res != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cc.z <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.wv;
    assign wr_dst   = 3'(st_q.wd);
    assign wr_data  = st_q.wdat;
    assign flag_n   = st_q.cc.n;
    assign flag_z   = st_q.cc.z;
    assign flag_p   = st_q.cc.p;

    a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({flag_n, flag_z, flag_p}));

    a_r6_flag_sign: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (flag_n == wr_data[DATA_W-1]) && (flag_z == (wr_data == '0)));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !wr_valid && $stable({flag_n, flag_z, flag_p}));

    a_r9_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> wr_valid && (wr_dst == 3'($past(dst))));
endmodule

// File: tb/opx_exec_bench.sv
module opx_exec_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic        wr_valid, flag_n, flag_z, flag_p;
    logic [2:0]  wr_dst;
    logic [15:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_reg [8];
    logic [2:0]  m_cc;

    always #(PERIOD/2) clk = ~clk;

    opx_exec u_opx_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .wr_valid(wr_valid), .wr_dst(wr_dst), .wr_data(wr_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] ins, input string tag);
        logic [3:0]  op;
        logic [15:0] a, b, r;
        logic        ok;
        @(negedge clk);
        in_valid = v;
        in_instr = ins;
        op = ins[15:12];
        ok = v && (op == 4'd1 || op == 4'd5 || op == 4'd9);
        a  = m_reg[ins[8:6]];
        b  = ins[5] ? 16'($signed(ins[4:0])) : m_reg[ins[2:0]];
        r  = (op == 4'd1) ? a + b : (op == 4'd5) ? (a & b) : ~a;
        @(posedge clk);
        #(PERIOD/4);
        if (ok) begin
            m_reg[ins[11:9]] = r;
            m_cc = r[15] ? 3'b100 : (r == 0) ? 3'b010 : 3'b001;
        end
        chk({tag, " wr_valid"}, 32'(wr_valid), 32'(ok));
        if (ok) begin
            chk({tag, " wr_dst"}, 32'(wr_dst), 32'(ins[11:9]));
            chk({tag, " wr_data"}, 32'(wr_data), 32'(r));
        end
        chk("R6 flags", 32'({flag_n, flag_z, flag_p}), 32'(m_cc));
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] ins;
        string t;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_cc = 3'b010;
        #(PERIOD * 3);
        @(negedge clk);
        chk("R1 flags", 32'({flag_n, flag_z, flag_p}), 32'(3'b010));
        chk("R1 wr_valid", 32'(wr_valid), 32'd0);
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i++) step(1'b1, {4'b0001, 3'(i), 3'(i), 6'b100000}, "R1");

        step(1'b1, 16'b0101_011_011_1_00000, "R4");          // clear R3
        step(1'b1, 16'b0001_011_011_1_00111, "R3");          // R3 = 7
        for (int i = 0; i < 12; i++)
            step(1'b1, 16'b0001_011_011_0_00_011, "R8");     // R3 += R3
        chk("R8 doubled", 32'(wr_data), 32'h7000);
        step(1'b1, 16'b0001_011_011_0_00_011, "R2");
        chk("R2 wrap", 32'(wr_data), 32'hE000);
        chk("R2 neg", 32'(flag_n), 32'd1);
        step(1'b1, 16'b0001_100_011_1_10001, "R3");          // R4 = R3 - 15
        chk("R3 minus15", 32'(wr_data), 32'hDFF1);
        step(1'b1, 16'b0101_101_011_1_11111, "R4");          // R5 = R3 & -1
        chk("R4 mask", 32'(wr_data), 32'hE000);
        step(1'b1, 16'b1001_110_011_111111, "R5");           // R6 = ~R3
        chk("R5 not", 32'(wr_data), 32'h1FFF);
        chk("R6 pos", 32'({flag_n, flag_z, flag_p}), 32'(3'b001));
        step(1'b0, 16'b0101_110_110_1_00000, "R7");          // dropped clear of R6
        step(1'b1, 16'b0000_110_110_1_00000, "R7");          // foreign opcode
        step(1'b1, 16'b1101_110_110_0_00_000, "R7");
        step(1'b1, 16'b0001_110_110_1_00000, "R7");          // read back R6
        chk("R7 kept", 32'(wr_data), 32'h1FFF);
        step(1'b1, 16'b0001_110_110_0_00_110, "R9");

        for (int i = 0; i < 1500; i++) begin
            ins = 16'($urandom);
            case ($urandom_range(0, 4))
                0: ins[15:12] = 4'b0001;
                1: ins[15:12] = 4'b0101;
                2: ins[15:12] = 4'b1001;
                default: ;
            endcase
            if (!ins[5] && ins[15:12] != 4'b1001) ins[4:3] = 2'b00;
            t = (ins[15:12] == 4'b0001) ? (ins[5] ? "R3" : "R2") :
                (ins[15:12] == 4'b0101) ? "R4" :
                (ins[15:12] == 4'b1001) ? "R5" : "R7";
            step(($urandom_range(0, 7) != 0), ins, t);
        end
        for (int i = 0; i < 8; i++) step(1'b1, {4'b0001, 3'(i), 3'(i), 6'b100000}, "R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule